// File: doc/BRIEF.md
# Keyboard Response Queue

This block sits on the receive side of a keyboard-facing serial channel. Key events arrive as a byte whose low seven bits pick an entry in a translation table and whose top bit flags a key release. The translated code, with the release bit OR-ed back on, is appended to a 256-byte receive queue. Command bytes that the host sends towards the keyboard are decoded here as well. Two of them, the reset command and the layout query, are answered by appending a fixed two-byte reply to the same queue. The other command bytes are dropped.

The host takes bytes out with a read request and gets the data one cycle later. A level output, `rx_avail`, tells the channel's status logic that at least one byte is waiting. Key events and command bytes use valid/ready handshakes. A source holds `valid` and its data steady until it sees `ready` high on a rising edge. `cmd_ready` is low only in the cycle after a recognised command, while the second reply byte is being queued. `key_ready` is low in that cycle and also in the cycle in which a recognised command is accepted. The queue filling up never applies back-pressure: when the queue is full, a byte that was accepted at the handshake is discarded.

Top module: `kbd_resp_queue`

## Requirements
- R1: After synchronous reset (`rst` high on a clock edge) the queue is empty, `rx_avail` is 0, `rd_ack` is 0, and `key_ready` and `cmd_ready` are both 1.
- R2: An accepted key event appends one byte. Its bits 6:0 are table entry `key_code[6:0]` and its bit 7 is `key_code[7]` OR-ed with bit 7 of that entry. The default table maps index i to (i*37+11) mod 128.
- R3: The queue holds up to 256 bytes and returns them in the order they were appended. An append while 256 bytes are stored is discarded, and the stored bytes stay as they were.
- R4: Every append that is not discarded leaves `rx_avail` at 1 from the next clock edge.
- R5: A read request while the queue is empty returns 0x00 and removes nothing.
- R6: After a read request removes a byte, `rx_avail` stays 1 only if at least one byte is still stored. Otherwise it drops to 0.
- R7: Command byte 0x01 appends 0xFF in the cycle it is accepted and 0x05 in the next cycle. `cmd_ready` is 0 during that next cycle.
- R8: Command byte 0x07 appends 0xFE in the cycle it is accepted and 0x20 in the next cycle.
- R9: Any other command byte appends nothing, and a key event offered in the same cycle is accepted in that cycle.
- R10: When a recognised command and a key event are offered in the same cycle, both reply bytes are appended first. `key_ready` stays 0 for those two cycles, and the key byte is appended in the cycle after.
- R11: A read and an append may happen in the same cycle. Whether the queue is full is judged before the read, so an append arriving at a full queue is discarded even if that cycle's read frees a slot.
- R12: Each read request is answered on the next clock edge with `rd_ack` high for one cycle and the byte (or 0x00) on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | Key event offered |
| key_ready | output | 1 | Key event accepted when high with `key_valid` |
| key_code | input | 8 | Bit 7 release flag, bits 6:0 table index |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte accepted when high with `cmd_valid` |
| cmd_byte | input | 8 | Command byte from the host |
| rd_req | input | 1 | Host read request (one byte per cycle) |
| rd_ack | output | 1 | Read answered, one cycle after `rd_req` |
| rd_data | output | 8 | Byte removed, or 0x00 when the queue was empty |
| rx_avail | output | 1 | At least one byte is waiting in the queue |

## Verification
Two pairs of functions can fall into the same cycle. The first pair is a recognised command and a key event, which compete for the single append port. The second pair is a host read and an append, which act on the queue together. The bench provokes the first pair by offering a key together with a reset command, a layout query and an unknown command. It checks the ready signals cycle by cycle and checks where the key byte lands in the read-back order. It provokes the second pair by reading and appending together at an empty queue and at a full queue, and also at random during a long mixed run. In every case the data read back and `rx_avail` are compared against a reference queue kept in the bench, which applies the full-before-read rule.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int BYTE_W    = 8;
  localparam int KEY_IDX_W = 7;
  localparam int KEY_COUNT = 1 << KEY_IDX_W;

  localparam logic [BYTE_W-1:0] CMD_RESET   = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_LAYOUT  = 8'h07;
  localparam logic [BYTE_W-1:0] RSP_RESET0  = 8'hFF;
  localparam logic [BYTE_W-1:0] RSP_RESET1  = 8'h05;
  localparam logic [BYTE_W-1:0] RSP_LAYOUT0 = 8'hFE;
  localparam logic [BYTE_W-1:0] RSP_LAYOUT1 = 8'h20;

  typedef struct packed {
    logic              valid;
    logic [BYTE_W-1:0] data;
  } push_t;

  // Placeholder mapping; real table is supplied by the integrator.
  function automatic logic [KEY_COUNT*BYTE_W-1:0] default_keymap();
    logic [KEY_COUNT*BYTE_W-1:0] m;
    m = '0;
    for (int i = 0; i < KEY_COUNT; i++) begin
      m[i*BYTE_W +: BYTE_W] = BYTE_W'((i * 37 + 11) % 128);
    end
    return m;
  endfunction
endpackage

// File: rtl/kbd_xlate.sv
module kbd_xlate
  import kbd_pkg::*;
#(
  parameter int IDX_W = KEY_IDX_W,
  parameter logic [(1<<IDX_W)*BYTE_W-1:0] MAP = default_keymap()
) (
  input  logic [IDX_W:0]     key_code,
  output logic [BYTE_W-1:0]  code_out
);
  logic [BYTE_W-1:0] entry;

  always_comb begin
    entry    = MAP[key_code[IDX_W-1:0]*BYTE_W +: BYTE_W];
    code_out = entry | {key_code[IDX_W], {(BYTE_W-1){1'b0}}};
  end
endmodule

// File: rtl/kbd_cmd_resp.sv
module kbd_cmd_resp
  import kbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_ready,
  output logic              hit,
  output push_t             push
);
  logic              pend_q;
  logic [BYTE_W-1:0] pend_byte_q;
  logic              known;
  logic [BYTE_W-1:0] first_b, second_b;

  always_comb begin
    known    = 1'b1;
    first_b  = '0;
    second_b = '0;
    unique case (cmd_byte)
      CMD_RESET:  begin first_b = RSP_RESET0;  second_b = RSP_RESET1;  end
      CMD_LAYOUT: begin first_b = RSP_LAYOUT0; second_b = RSP_LAYOUT1; end
      default:    known = 1'b0;
    endcase
    cmd_ready  = !pend_q;
    hit        = cmd_valid && cmd_ready && known;
    push.valid = pend_q || hit;
    push.data  = pend_q ? pend_byte_q : first_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_byte_q <= '0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
    end else if (hit) begin
      pend_q      <= 1'b1;
      pend_byte_q <= second_b;
    end
  end
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo
  import kbd_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  push_t             push,
  input  logic              pop,
  output logic [BYTE_W-1:0] pop_data,
  output logic              pop_ack,
  output logic [CNT_W-1:0]  fill,
  output logic              push_taken,
  output logic              pop_taken
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  always_comb begin
    push_taken = push.valid && (fill != FULL_CNT);
    pop_taken  = pop && (fill != '0);
  end

  always_ff @(posedge clk) begin
    if (push_taken) mem[wptr] <= push.data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      pop_data <= '0;
      pop_ack  <= 1'b0;
    end else begin
      pop_ack  <= pop;
      pop_data <= pop_taken ? mem[rptr] : '0;
      if (push_taken) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (pop_taken)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      case ({push_taken, pop_taken})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/kbd_resp_queue.sv
module kbd_resp_queue
  import kbd_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter logic [KEY_COUNT*BYTE_W-1:0] KEY_MAP = default_keymap()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [BYTE_W-1:0] key_code,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              rd_req,
  output logic              rd_ack,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rx_avail
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic              cmd_hit;
  push_t             resp_push, q_push;
  logic [BYTE_W-1:0] key_xl;
  logic [CNT_W-1:0]  fill;
  logic              push_taken, pop_taken;

  kbd_cmd_resp u_resp (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_ready(cmd_ready), .hit(cmd_hit), .push(resp_push)
  );

  kbd_xlate #(.IDX_W(KEY_IDX_W), .MAP(KEY_MAP)) u_xlate (
    .key_code(key_code), .code_out(key_xl)
  );

  always_comb begin
    key_ready = cmd_ready && !cmd_hit;
    if (resp_push.valid) q_push = resp_push;
    else                 q_push = '{valid: key_valid && key_ready, data: key_xl};
  end

  kbd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push), .pop(rd_req),
    .pop_data(rd_data), .pop_ack(rd_ack), .fill(fill),
    .push_taken(push_taken), .pop_taken(pop_taken)
  );

  always_ff @(posedge clk) begin
    if (rst)             rx_avail <= 1'b0;
    else if (push_taken) rx_avail <= 1'b1;
    else if (pop_taken)  rx_avail <= (fill > CNT_W'(1));
  end
endmodule

// File: rtl/kbd_resp_queue_chk.sv
module kbd_resp_queue_chk
  import kbd_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  fill,
  input logic              rx_avail,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [BYTE_W-1:0] rd_data,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [BYTE_W-1:0] cmd_byte,
  input logic              key_ready
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH));

  assert_avail_tracks_R4: assert property (@(posedge clk) disable iff (rst)
    rx_avail == (fill != '0));

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && fill == '0) |=> (rd_data == '0));

  assert_reset_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_byte == CMD_RESET) |=> !cmd_ready);

  assert_key_held_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |-> !key_ready);

  assert_read_ack_R12: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_ack);
endmodule

bind kbd_resp_queue kbd_resp_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .fill(fill), .rx_avail(rx_avail), .rd_req(rd_req),
  .rd_ack(rd_ack), .rd_data(rd_data), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_byte(cmd_byte), .key_ready(key_ready)
);

// File: tb/test_kbd_resp_queue.sv
module test_kbd_resp_queue;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_valid = 1'b0, cmd_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] key_code = '0, cmd_byte = '0;
  logic key_ready, cmd_ready, rd_ack, rx_avail;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  kbd_resp_queue i_kbd_resp_queue (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data), .rx_avail(rx_avail)
  );

  int tests = 0, fails = 0;
  logic [7:0] mq [256];
  int m_head = 0, m_cnt = 0;
  logic m_pend = 1'b0;
  logic [7:0] m_pbyte = '0;
  logic m_ktaken;

  function automatic logic [7:0] xl(input logic [7:0] k);
    return 8'((int'(k[6:0]) * 37 + 11) % 128) | {k[7], 7'b0};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic kv, input logic [7:0] kc, input logic cv,
                     input logic [7:0] cb, input logic rr, input string tag);
    logic pend_old, known, have, full;
    logic [7:0] pb, exp_rd;
    @(negedge clk);
    key_valid = kv; key_code = kc; cmd_valid = cv; cmd_byte = cb; rd_req = rr;
    #1;
    pend_old = m_pend;
    known = cv && !pend_old && (cb == 8'h01 || cb == 8'h07);
    chk(cmd_ready == !pend_old, {tag, " R7 cmd_ready"}, cmd_ready, !pend_old);
    chk(key_ready == (!pend_old && !known), {tag, " R10 key_ready"},
        key_ready, !pend_old && !known);
    have = 1'b0; pb = '0; m_ktaken = 1'b0;
    if (pend_old) begin
      have = 1'b1; pb = m_pbyte; m_pend = 1'b0;
    end else if (known) begin
      have = 1'b1; m_pend = 1'b1;
      pb      = (cb == 8'h01) ? 8'hFF : 8'hFE;
      m_pbyte = (cb == 8'h01) ? 8'h05 : 8'h20;
    end else if (kv) begin
      have = 1'b1; pb = xl(kc); m_ktaken = 1'b1;
    end
    full = (m_cnt == 256);
    exp_rd = '0;
    if (rr && m_cnt > 0) begin
      exp_rd = mq[m_head]; m_head = (m_head + 1) % 256; m_cnt--;
    end
    if (have && !full) begin
      mq[(m_head + m_cnt) % 256] = pb; m_cnt++;
    end
    @(posedge clk); #2;
    key_valid = 1'b0; cmd_valid = 1'b0; rd_req = 1'b0;
    if (rr) begin
      chk(rd_ack == 1'b1, {tag, " R12 rd_ack"}, rd_ack, 1);
      chk(rd_data == exp_rd, {tag, " R3/R5 rd_data"}, rd_data, exp_rd);
    end
    chk(rx_avail == (m_cnt != 0), {tag, " R4/R6 rx_avail"}, rx_avail, m_cnt != 0);
  endtask

  task automatic key_until_taken(input logic [7:0] kc, input logic cv,
                                 input logic [7:0] cb, input string tag);
    cyc(1'b1, kc, cv, cb, 1'b0, tag);
    while (!m_ktaken) cyc(1'b1, kc, 1'b0, 8'h00, 1'b0, tag);
  endtask

  task automatic drain(input string tag);
    while (m_cnt > 0) cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    logic kv, cv, rr;
    logic [7:0] kc, cb;
    unused_seed = $urandom(32'd20251);
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    #1;
    chk(rx_avail == 1'b0, "R1 rx_avail", rx_avail, 0);
    chk(rd_ack == 1'b0, "R1 rd_ack", rd_ack, 0);
    chk(key_ready && cmd_ready, "R1 readies", {key_ready, cmd_ready}, 3);

    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R5 empty read");
    cyc(1'b1, 8'h05, 1'b0, 8'h00, 1'b0, "R2 press");
    cyc(1'b1, 8'h85, 1'b0, 8'h00, 1'b0, "R2 release");
    cyc(1'b1, 8'h7F, 1'b0, 8'h00, 1'b0, "R2 top index");
    drain("R6 drain keys");
    cyc(1'b0, 8'h00, 1'b1, 8'h01, 1'b0, "R7 reset cmd");
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R7 second byte");
    drain("R7 read reply");
    cyc(1'b0, 8'h00, 1'b1, 8'h07, 1'b0, "R8 layout cmd");
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R11 read during reply");
    drain("R8 read reply");
    key_until_taken(8'h10, 1'b1, 8'h33, "R9 unknown cmd with key");
    key_until_taken(8'h22, 1'b1, 8'h01, "R10 reset cmd with key");
    key_until_taken(8'hA2, 1'b1, 8'h07, "R10 layout cmd with key");
    drain("R10 order");

    for (int i = 0; i < 260; i++)
      cyc(1'b1, 8'(i), 1'b0, 8'h00, 1'b0, "R3 fill");
    cyc(1'b1, 8'h44, 1'b0, 8'h00, 1'b1, "R11 full push with pop");
    cyc(1'b1, 8'h45, 1'b0, 8'h00, 1'b1, "R11 push with pop");
    drain("R3 drain full");
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R5 empty after drain");
    cyc(1'b1, 8'h01, 1'b0, 8'h00, 1'b1, "R11 empty push with pop");
    drain("R6 last byte");

    kv = 1'b0; kc = '0;
    for (int n = 0; n < 4000; n++) begin
      if (!kv) begin
        kv = ($urandom_range(0, 9) < 6);
        kc = 8'($urandom);
      end
      cv = ($urandom_range(0, 9) == 0) && !m_pend;
      case ($urandom_range(0, 2))
        0: cb = 8'h01;
        1: cb = 8'h07;
        default: cb = 8'($urandom);
      endcase
      rr = ($urandom_range(0, 9) < ((n / 500) % 2 == 0 ? 3 : 7));
      cyc(kv, kc, cv, cb, rr, "R3/R10 random");
      if (m_ktaken) kv = 1'b0;
    end
    drain("R3 final drain");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule